// File: doc/BRIEF.md
# Complementary-Redundant Logic Unit

This unit performs bitwise AND, XOR and XNOR on 32-bit operands stored in complementary-redundant form. In this form, some slices of a word hold a bit's true value and other slices hold its inverse. A plain bitwise operation would break that encoding. This unit gives the true slices the requested operation and the complemented slices its De Morgan dual. The encoding therefore survives a single operation, where emulating it with ordinary logic would take about five.

Two slice layouts are supported. In half mode, the upper 16 bits are the complemented region and the lower 16 bits are the true region. In byte mode, bytes 3 and 1 are complemented and bytes 2 and 0 are true. Each request is captured on a valid strobe. The result appears one clock later, together with an output valid and a flag for an unsupported opcode.

Top module: `cred_logic_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, before any request, out_valid, illegal and result are all zero.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high, and low otherwise.
- R3: With byte_mode = 0, bits 31:16 are the complemented region and bits 15:0 are the true region.
- R4: With byte_mode = 1, the complemented region is mask 0xFF00FF00 (bytes 3 and 1) and the true region is mask 0x00FF00FF (bytes 2 and 0).
- R5: Opcode 2'b00 (AND) gives a AND b in true bits and a OR b in complemented bits.
- R6: Opcode 2'b01 (XOR) gives a XOR b in true bits and a XNOR b in complemented bits.
- R7: Opcode 2'b10 (XNOR) gives a XNOR b in true bits and a XOR b in complemented bits.
- R8: Opcode 2'b11 is reserved. It yields result zero and illegal high in the output cycle. illegal is low for every other accepted opcode.
- R9: In a cycle without in_valid, result and illegal keep their previous values.
- R10: When both operands are valid encodings for the selected mode, a legal operation yields a valid encoding. Each complemented slice of the result equals the inverse of its paired true slice: bits 31:16 against 15:0 in half mode, and bytes 3/2 and 1/0 in byte mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 2 | 00 AND, 01 XOR, 10 XNOR, 11 reserved |
| byte_mode | input | 1 | 0 = 16-bit halves, 1 = 8-bit bytes |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Registered result |
| illegal | output | 1 | Reserved opcode was requested |

## Verification
The following are checked on every cycle:
- the one-cycle valid handshake;
- the reserved-opcode response;
- the AND, XOR and XNOR results against the operands sampled a cycle earlier, in both layouts;
- that outputs hold when idle;
- that a valid encoding stays valid.

The bench's scenarios add what only chosen stimulus can show:
- the reset values;
- that the slice layout follows byte_mode, using operands that tell the two masks apart;
- back-to-back requests;
- the reserved opcode followed directly by a legal one;
- preservation across a spread of randomly encoded operands.

// File: rtl/cred_logic_unit.sv
module cred_logic_unit #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] HALF_MASK = 32'hFFFF_0000,
  parameter logic [DATA_W-1:0] BYTE_MASK = 32'hFF00_FF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        opcode,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam logic [1:0] OP_AND  = 2'b00;
  localparam logic [1:0] OP_XOR  = 2'b01;
  localparam logic [1:0] OP_XNOR = 2'b10;

  logic [DATA_W-1:0] comp_mask, true_v, dual_v, next_v;
  logic              bad_op;

  assign comp_mask = byte_mode ? BYTE_MASK : HALF_MASK;

  always_comb begin
    bad_op = 1'b0;
    case (opcode)
      OP_AND:  begin true_v = op_a & op_b;     dual_v = op_a | op_b;     end
      OP_XOR:  begin true_v = op_a ^ op_b;     dual_v = ~(op_a ^ op_b);  end
      OP_XNOR: begin true_v = ~(op_a ^ op_b);  dual_v = op_a ^ op_b;     end
      default: begin true_v = '0; dual_v = '0; bad_op = 1'b1;            end
    endcase
  end

  assign next_v = (true_v & ~comp_mask) | (dual_v & comp_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_v;
        illegal <= bad_op;
      end
    end
  end
endmodule

// File: rtl/cred_logic_chk.sv
module cred_logic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  opcode,
  input logic        byte_mode,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        illegal
);
  function automatic logic enc_ok(input logic [31:0] x, input logic bm);
    if (bm) return (x[31:24] == ~x[23:16]) && (x[15:8] == ~x[7:0]);
    return x[31:16] == ~x[15:0];
  endfunction

  function automatic logic [31:0] cmask(input logic bm);
    return bm ? 32'hFF00_FF00 : 32'hFFFF_0000;
  endfunction

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'b11) |=> (illegal && result == 32'h0));
  // R8
  legal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode != 2'b11) |=> !illegal);
  // R5
  and_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'b00) |=>
      result == ((($past(op_a) & $past(op_b)) & ~cmask($past(byte_mode))) |
                 (($past(op_a) | $past(op_b)) &  cmask($past(byte_mode)))));
  // R6
  xor_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'b01) |=>
      (result ^ $past(op_a) ^ $past(op_b)) == cmask($past(byte_mode)));
  // R7
  xnor_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'b10) |=>
      (result ^ $past(op_a) ^ $past(op_b)) == ~cmask($past(byte_mode)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));
  // R10
  enc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode != 2'b11 && enc_ok(op_a, byte_mode) && enc_ok(op_b, byte_mode))
      |=> enc_ok(result, $past(byte_mode)));
endmodule

bind cred_logic_unit cred_logic_chk u_chk (.*);

// File: tb/test_cred_logic_unit.sv
module test_cred_logic_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic        byte_mode = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid, illegal;
  logic [31:0] result;
  int total = 0, bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  cred_logic_unit i_cred_logic_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .byte_mode(byte_mode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .illegal(illegal));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] op, input logic bm);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic comp;
      comp = bm ? (((i / 8) % 2) == 1) : (i >= 16);
      case (op)
        2'b00: r[i] = comp ? (a[i] | b[i]) : (a[i] & b[i]);
        2'b01: r[i] = comp ? ~(a[i] ^ b[i]) : (a[i] ^ b[i]);
        2'b10: r[i] = comp ? (a[i] ^ b[i]) : ~(a[i] ^ b[i]);
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] encode(input logic [31:0] raw, input logic bm);
    if (bm) return {~raw[23:16], raw[23:16], ~raw[7:0], raw[7:0]};
    return {~raw[15:0], raw[15:0]};
  endfunction

  function automatic logic enc_ok(input logic [31:0] x, input logic bm);
    if (bm) return (x[31:24] == ~x[23:16]) && (x[15:8] == ~x[7:0]);
    return x[31:16] == ~x[15:0];
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; returns after the output cycle, sampled at negedge
  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] op, input logic bm);
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; byte_mode = bm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 32'h0);
    check(result == 32'h0, "R1 result", result, 32'h0);
    check(illegal == 1'b0, "R1 illegal", {31'b0, illegal}, 32'h0);
  endtask

  task automatic t_op(input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] op, input logic bm, input string tag);
    logic [31:0] exp;
    exp = model(a, b, op, bm);
    issue(a, b, op, bm);
    check(out_valid == 1'b1, {tag, " R2 valid"}, {31'b0, out_valid}, 32'h1);
    check(result == exp, tag, result, exp);
    check(illegal == 1'b0, {tag, " R8 flag"}, {31'b0, illegal}, 32'h0);
  endtask

  task automatic t_layout();
    // operands 0 and all-ones: AND gives 1 only where complemented (R3, R4)
    issue(32'h0, 32'hFFFF_FFFF, 2'b00, 1'b0);
    check(result == 32'hFFFF_0000, "R3 half mask", result, 32'hFFFF_0000);
    issue(32'h0, 32'hFFFF_FFFF, 2'b00, 1'b1);
    check(result == 32'hFF00_FF00, "R4 byte mask", result, 32'hFF00_FF00);
  endtask

  task automatic t_reserved();
    issue(32'hDEAD_BEEF, 32'h1234_5678, 2'b11, 1'b0);
    check(result == 32'h0, "R8 zero result", result, 32'h0);
    check(illegal == 1'b1, "R8 flag high", {31'b0, illegal}, 32'h1);
    t_op(32'hA5A5_5A5A, 32'h0F0F_F0F0, 2'b01, 1'b1, "R6 after reserved");
  endtask

  task automatic t_hold();
    logic [31:0] prev;
    issue(32'h1357_9BDF, 32'h2468_ACE0, 2'b10, 1'b0);
    prev = model(32'h1357_9BDF, 32'h2468_ACE0, 2'b10, 1'b0);
    op_a = 32'hFFFF_FFFF; op_b = 32'h0; opcode = 2'b11;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2 idle valid", {31'b0, out_valid}, 32'h0);
    check(result == prev, "R9 hold result", result, prev);
    check(illegal == 1'b0, "R9 hold flag", {31'b0, illegal}, 32'h0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] e1, e2;
    e1 = model(32'hCAFE_F00D, 32'h0BAD_C0DE, 2'b00, 1'b1);
    e2 = model(32'h8000_0001, 32'h7FFF_FFFE, 2'b01, 1'b0);
    @(negedge clk);
    op_a = 32'hCAFE_F00D; op_b = 32'h0BAD_C0DE; opcode = 2'b00; byte_mode = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check(result == e1 && out_valid, "R2 R5 b2b first", result, e1);
    op_a = 32'h8000_0001; op_b = 32'h7FFF_FFFE; opcode = 2'b01; byte_mode = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(result == e2 && out_valid, "R2 R6 b2b second", result, e2);
  endtask

  task automatic t_preserve();
    for (int n = 0; n < 48; n++) begin
      logic [31:0] a, b;
      logic bm;
      logic [1:0] op;
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      bm = seed[7];
      op = 2'(n % 3);
      a = encode(a, bm);
      b = encode(b, bm);
      issue(a, b, op, bm);
      check(enc_ok(result, bm), "R10 encoding kept", result, model(a, b, op, bm));
      check(result == model(a, b, op, bm), "R10 value", result, model(a, b, op, bm));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_op(32'hF0F0_3C3C, 32'hFF00_0FF0, 2'b00, 1'b0, "R5 AND half");
    t_op(32'hF0F0_3C3C, 32'hFF00_0FF0, 2'b00, 1'b1, "R5 AND byte");
    t_op(32'h9999_6666, 32'h5555_AAAA, 2'b01, 1'b0, "R6 XOR half");
    t_op(32'h9999_6666, 32'h5555_AAAA, 2'b01, 1'b1, "R6 XOR byte");
    t_op(32'h0123_4567, 32'h89AB_CDEF, 2'b10, 1'b0, "R7 XNOR half");
    t_op(32'h0123_4567, 32'h89AB_CDEF, 2'b10, 1'b1, "R7 XNOR byte");
    t_reserved();
    t_hold();
    t_back_to_back();
    t_preserve();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule